// File: doc/BRIEF.md
# Capture Line Address Generator

This block produces the memory write addresses for video lines as a capture engine stores them. A field-start strobe loads the line pointer from a base address. Each line-end strobe then moves the pointer on by a programmed pitch. Two storage layouts are supported. In the linear layout all pixel data shares one buffer. In the planar layout a second pointer is also kept for the V plane. That pointer starts at the base plus a V-plane offset and moves by the same pitch.

The pitch and offset have alignment rules, and these depend on the layout. A configuration that breaks them puts the block into a fault state. While it is faulted, `align_err` is high and both pointers are frozen. A field start with a legal configuration restarts capture. The memory master that consumes the addresses lies outside this block. The V-plane offset is not double-buffered, so software must program it before capture starts.

Top module: `line_addr_gen`

## Requirements
- R1: After reset, `line_addr` and `v_addr` are zero and `align_err` is low.
- R2: A `field_start` with an acceptable configuration loads `line_addr` with `base` and `v_addr` with `base + v_offset` (modulo 2^32), and clears `align_err`; the outputs change on the clock edge that samples the strobe.
- R3: Once a field has been accepted, each `line_end` with an acceptable configuration adds the zero-extended 16-bit `pitch` to `line_addr`; the sum wraps modulo 2^32.
- R4: At each such `line_end`, `v_addr` also advances by `pitch` when `planar` is 1. When `planar` is 0, `v_addr` holds its value.
- R5: With `planar` = 0, the configuration is acceptable exactly when `pitch[4:0]` is zero; `v_offset` is not checked.
- R6: With `planar` = 1, the configuration is acceptable exactly when `pitch[5:0]` is zero and `v_offset[4:0]` is zero.
- R7: A `field_start`, or a `line_end` during an accepted field, that arrives with an unacceptable configuration sets `align_err` on the next edge and leaves both addresses unchanged.
- R8: While `align_err` is high, `line_end` has no effect, even once the configuration is legal again. Only an acceptable `field_start` clears the fault.
- R9: A `line_end` before the first accepted `field_start` (after reset or after a fault) leaves both addresses unchanged.
- R10: When `field_start` and `line_end` occur in the same cycle, the load takes priority and the step is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| field_start | input | 1 | One-cycle strobe that starts a field |
| line_end | input | 1 | One-cycle strobe that ends a line |
| planar | input | 1 | 1 selects the planar layout, 0 the linear layout |
| base | input | 32 | Buffer base address |
| pitch | input | 16 | Line-to-line address step |
| v_offset | input | 32 | V-plane start relative to base |
| line_addr | output | 32 | Current line start address |
| v_addr | output | 32 | Current V-plane line start address |
| align_err | output | 1 | Alignment fault; pointers are frozen while it is high |

## Verification
The bench sweeps every single-bit pitch value from 1 to 32 in both layouts. This exposes any design that checks the same number of low bits for both layouts: such a design either accepts a 32-byte pitch in planar mode or rejects it in linear mode. The bench also sets each low bit of the offset in turn. This catches a design that checks the offset in linear mode, or fails to check it in planar mode. Other runs enter the fault state and fix the pitch without a new field start, strobe both inputs in the same cycle, and step a pointer across the top of the 32-bit address space. Each of these shows up as a pointer that moves when it must not, or a wrong wrapped address.

// File: rtl/lag_pkg.sv
// Package: shared constants and the control state type for the line
// address generator. Assumes byte addresses.
package lag_pkg;
    // Low address bits that must be zero in each layout.
    localparam int LIN_PITCH_LSBS = 5;
    localparam int PLN_PITCH_LSBS = 6;
    localparam int VOFF_LSBS      = 5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } lag_state_e;
endpackage

// File: rtl/lag_align_chk.sv
// Module: lag_align_chk
// Decides from the live inputs whether the pitch and the V offset meet the
// alignment rule of the selected layout. Purely combinational.
// Assumes PITCH_W and ADDR_W both exceed the widest rule in lag_pkg.
module lag_align_chk
    import lag_pkg::*;
#(
    parameter int PITCH_W = 16,
    parameter int ADDR_W  = 32
) (
    input  logic               planar,
    input  logic [PITCH_W-1:0] pitch,
    input  logic [ADDR_W-1:0]  v_offset,
    output logic               cfg_ok
);
    logic lin_ok;
    logic pln_pitch_ok;
    logic voff_ok;

    // Evaluate each alignment rule separately, then pick by layout.
    always_comb begin
        lin_ok       = (pitch[LIN_PITCH_LSBS-1:0] == '0);
        pln_pitch_ok = (pitch[PLN_PITCH_LSBS-1:0] == '0);
        voff_ok      = (v_offset[VOFF_LSBS-1:0] == '0);
        cfg_ok       = planar ? (pln_pitch_ok && voff_ok) : lin_ok;
    end
endmodule

// File: rtl/lag_ctrl.sv
// Module: lag_ctrl
// Control for the generator. IDLE waits for an accepted field, RUN steps
// on line ends, and HALT holds the pointers after an alignment fault until
// an acceptable field start arrives. field_start outranks line_end.
// Assumes the strobes are single-cycle pulses synchronous to clk.
module lag_ctrl
    import lag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic field_start,
    input  logic line_end,
    input  logic cfg_ok,
    output logic load,
    output logic step,
    output logic align_err
);
    lag_state_e state_q, state_d;
    logic       fault;

    // Decode load, step and fault requests and the next state.
    always_comb begin
        load    = field_start && cfg_ok;
        step    = !field_start && line_end && cfg_ok && (state_q == ST_RUN);
        fault   = (field_start && !cfg_ok) ||
                  (!field_start && line_end && !cfg_ok && (state_q == ST_RUN));
        state_d = state_q;
        if (load)       state_d = ST_RUN;
        else if (fault) state_d = ST_HALT;
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // The fault flag is taken straight from the registered state.
    always_comb align_err = (state_q == ST_HALT);
endmodule

// File: rtl/lag_ptr.sv
// Module: lag_ptr
// One address pointer. It loads a start value or adds the zero-extended
// pitch; load has priority. Assumes ADDR_W > PITCH_W; the sum wraps.
module lag_ptr #(
    parameter int ADDR_W  = 32,
    parameter int PITCH_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [ADDR_W-1:0]  load_val,
    input  logic               step,
    input  logic [PITCH_W-1:0] pitch,
    output logic [ADDR_W-1:0]  q
);
    localparam int EXT_W = ADDR_W - PITCH_W;

    logic [ADDR_W-1:0] pitch_ext;

    // Zero-extend the pitch to address width.
    always_comb pitch_ext = {{EXT_W{1'b0}}, pitch};

    // Pointer register: reset to zero, then load or step.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= load_val;
        else if (step) q <= q + pitch_ext;
    end
endmodule

// File: rtl/line_addr_gen.sv
// Module: line_addr_gen (top)
// Generates the line start addresses for captured video: a main pointer, and
// a V-plane pointer that starts at base + v_offset and steps only in planar
// layout. Assumes the configuration is held steady within a cycle, and that
// v_offset is programmed before the field starts.
module line_addr_gen #(
    parameter int ADDR_W  = 32,
    parameter int PITCH_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               field_start,
    input  logic               line_end,
    input  logic               planar,
    input  logic [ADDR_W-1:0]  base,
    input  logic [PITCH_W-1:0] pitch,
    input  logic [ADDR_W-1:0]  v_offset,
    output logic [ADDR_W-1:0]  line_addr,
    output logic [ADDR_W-1:0]  v_addr,
    output logic               align_err
);
    logic              cfg_ok;
    logic              load;
    logic              step;
    logic              v_step;
    logic [ADDR_W-1:0] v_start;

    // Work out the V-plane start address and gate its step by layout.
    always_comb begin
        v_start = base + v_offset;
        v_step  = step && planar;
    end

    lag_align_chk #(.PITCH_W(PITCH_W), .ADDR_W(ADDR_W)) u_align (
        .planar   (planar),
        .pitch    (pitch),
        .v_offset (v_offset),
        .cfg_ok   (cfg_ok)
    );

    lag_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .field_start (field_start),
        .line_end    (line_end),
        .cfg_ok      (cfg_ok),
        .load        (load),
        .step        (step),
        .align_err   (align_err)
    );

    lag_ptr #(.ADDR_W(ADDR_W), .PITCH_W(PITCH_W)) u_line_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (base),
        .step     (step),
        .pitch    (pitch),
        .q        (line_addr)
    );

    lag_ptr #(.ADDR_W(ADDR_W), .PITCH_W(PITCH_W)) u_v_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (v_start),
        .step     (v_step),
        .pitch    (pitch),
        .q        (v_addr)
    );
endmodule

// File: rtl/lag_chk.sv
// Module: lag_chk
// Property checker bound to line_addr_gen. It keeps its own record of
// whether a field is active and applies the alignment rules separately.
module lag_chk #(
    parameter int ADDR_W  = 32,
    parameter int PITCH_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               field_start,
    input logic               line_end,
    input logic               planar,
    input logic [ADDR_W-1:0]  base,
    input logic [PITCH_W-1:0] pitch,
    input logic [ADDR_W-1:0]  v_offset,
    input logic [ADDR_W-1:0]  line_addr,
    input logic [ADDR_W-1:0]  v_addr,
    input logic               align_err
);
    logic ok;
    logic armed;

    // Checker copy of the alignment rules, taken from the layout definitions.
    always_comb ok = planar ? (pitch[5:0] == 6'd0 && v_offset[4:0] == 5'd0)
                            : (pitch[4:0] == 5'd0);

    // Track whether an accepted field is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n)                          armed <= 1'b0;
        else if (field_start)                armed <= ok;
        else if (line_end && armed && !ok)   armed <= 1'b0;
    end

    // R2
    load_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        field_start && ok |=> line_addr == $past(base) &&
        v_addr == $past(base) + $past(v_offset) && !align_err);

    // R7
    bad_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        field_start && !ok |=> align_err && $stable(line_addr) && $stable(v_addr));

    // R3
    line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !field_start && line_end && ok && armed |=>
        line_addr == $past(line_addr) + ADDR_W'($past(pitch)));

    // R4
    v_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !field_start && !(line_end && planar) |=> $stable(v_addr));

    // R8
    halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        align_err && !field_start |=> align_err && $stable(line_addr));

    // R9
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed && !field_start |=> $stable(line_addr) && $stable(v_addr));
endmodule

bind line_addr_gen lag_chk #(.ADDR_W(ADDR_W), .PITCH_W(PITCH_W)) u_lag_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .field_start (field_start),
    .line_end    (line_end),
    .planar      (planar),
    .base        (base),
    .pitch       (pitch),
    .v_offset    (v_offset),
    .line_addr   (line_addr),
    .v_addr      (v_addr),
    .align_err   (align_err)
);

// File: tb/sim_line_addr_gen.sv
module sim_line_addr_gen;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        field_start = 1'b0;
    logic        line_end = 1'b0;
    logic        planar = 1'b0;
    logic [31:0] base = '0;
    logic [15:0] pitch = '0;
    logic [31:0] v_offset = '0;
    logic [31:0] line_addr;
    logic [31:0] v_addr;
    logic        align_err;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    line_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .field_start(field_start), .line_end(line_end),
        .planar(planar), .base(base), .pitch(pitch), .v_offset(v_offset),
        .line_addr(line_addr), .v_addr(v_addr), .align_err(align_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive strobes for one cycle; outputs are settled by the following negedge.
    task automatic pulse(input logic fs, input logic le);
        @(negedge clk);
        field_start = fs;
        line_end    = le;
        @(negedge clk);
        field_start = 1'b0;
        line_end    = 1'b0;
    endtask

    initial begin
        logic [31:0] eb, ev, bprev, vprev;
        logic        exp_err;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 line", line_addr, 32'h0);
        chk("R1 v", v_addr, 32'h0);
        chk("R1 err", {31'b0, align_err}, 32'h0);
        rst_n = 1'b1;

        // R9: line end before any accepted field
        pitch = 16'h0040;
        pulse(1'b0, 1'b1);
        chk("R9 line", line_addr, 32'h0);
        chk("R9 v", v_addr, 32'h0);

        // R2 R3 R4: sweep layouts and pitches over several lines
        for (int pl = 0; pl < 2; pl++) begin
            for (int pk = 1; pk <= 4; pk++) begin
                planar   = pl[0];
                pitch    = 16'(pk * 64 + (pl == 0 ? 32 : 0));
                base     = 32'h1000_0000 + 32'(pk * 4096);
                v_offset = 32'h0020_0000 + 32'(pk * 32);
                pulse(1'b1, 1'b0);
                chk("R2 line", line_addr, base);
                chk("R2 v", v_addr, base + v_offset);
                chk("R2 err", {31'b0, align_err}, 32'h0);
                for (int n = 1; n <= 6; n++) begin
                    pulse(1'b0, 1'b1);
                    chk("R3 line", line_addr, base + 32'(n) * 32'(pitch));
                    chk("R4 v", v_addr, base + v_offset + (pl == 1 ? 32'(n) * 32'(pitch) : 32'h0));
                end
            end
        end

        // R3: wrap across the top of the address space
        planar = 1'b0; base = 32'hFFFF_FF00; pitch = 16'h0080; v_offset = 32'h0;
        pulse(1'b1, 1'b0);
        for (int n = 0; n < 3; n++) pulse(1'b0, 1'b1);
        chk("R3 wrap", line_addr, 32'h0000_0080);

        // R5 R6 R7: every single-bit pitch from bit 0 to bit 5 in both layouts
        for (int pl = 0; pl < 2; pl++) begin
            for (int b = 0; b < 6; b++) begin
                planar = pl[0]; v_offset = 32'h0; pitch = 16'h0040; base = 32'h0000_4000;
                pulse(1'b1, 1'b0);
                pitch   = 16'(1 << b);
                base    = 32'h0000_8000;
                exp_err = (pl == 1) ? 1'b1 : (b < 5);
                pulse(1'b1, 1'b0);
                chk(pl == 1 ? "R6 pitch err" : "R5 pitch err", {31'b0, align_err}, {31'b0, exp_err});
                chk("R7 hold", line_addr, exp_err ? 32'h0000_4000 : 32'h0000_8000);
            end
        end

        // R5 R6: each low offset bit in both layouts
        for (int pl = 0; pl < 2; pl++) begin
            for (int b = 0; b < 5; b++) begin
                planar = pl[0]; pitch = 16'h0040; base = 32'h0001_0000;
                v_offset = 32'h0000_1000 | 32'(1 << b);
                pulse(1'b1, 1'b0);
                chk(pl == 1 ? "R6 offset err" : "R5 offset ignored",
                    {31'b0, align_err}, {31'b0, pl[0]});
            end
        end

        // R7: bad pitch at a line end inside a field
        planar = 1'b1; pitch = 16'h0040; v_offset = 32'h100; base = 32'h0002_0000;
        pulse(1'b1, 1'b0);
        pulse(1'b0, 1'b1);
        bprev = line_addr; vprev = v_addr;
        pitch = 16'h0020;
        pulse(1'b0, 1'b1);
        chk("R7 err", {31'b0, align_err}, 32'h1);
        chk("R7 line", line_addr, bprev);
        chk("R7 v", v_addr, vprev);

        // R8: legal pitch again, but a line end must not step or clear the fault
        pitch = 16'h0040;
        pulse(1'b0, 1'b1);
        chk("R8 err", {31'b0, align_err}, 32'h1);
        chk("R8 line", line_addr, bprev);
        base = 32'h0003_0000;
        pulse(1'b1, 1'b0);
        chk("R8 clear", {31'b0, align_err}, 32'h0);
        chk("R8 reload", line_addr, 32'h0003_0000);

        // R10: both strobes together give the load only
        pulse(1'b0, 1'b1);
        base = 32'h0004_0000;
        pulse(1'b1, 1'b1);
        eb = 32'h0004_0000; ev = eb + 32'h100;
        chk("R10 line", line_addr, eb);
        chk("R10 v", v_addr, ev);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule